// File: doc/BRIEF.md
# Prioritized Interrupt Merger with Vector Readout

This block gathers ten interrupt request pins into a single active-low interrupt line for a processor. Each request pin has its own polarity. The block also answers a bus read with a byte that names the pending request of highest priority. That byte is the winning index multiplied by two, so a handler can use it directly as a byte offset into a table of two-byte handler addresses.

The interrupt line is purely combinational, so it follows the request pins with no clock delay. The readout byte comes from a register that is reloaded on every rising clock edge. A request that changes between edges therefore cannot disturb a read already in progress.

The block has no writable state. A bus cycle with write enable asserted only releases the bus. The byte has no valid/ready handshake: it is presented on a shared tri-state bus whenever the block is selected for reading.

Top module: `irq_vector_merge`

## Requirements
- R1: `irq_n` is 0 in the same cycle that at least one request is active, and 1 when none is active. No clock edge is needed.
- R2: Request pins 2 and 5 are active when high. Pins 0, 1, 3, 4, 6, 7, 8 and 9 are active when low.
- R3: When several requests are active, the lowest-numbered one wins the readout.
- R4: When no request is active, the reported index is 10 (a phantom interrupt), so the byte reads 0x14.
- R5: The byte equals the winning index times two. Bit 0 is 0, the 4-bit index sits in bits 4..1, and bits 7..5 are 0.
- R6: The byte reflects the requests sampled at the most recent rising clock edge. A request change between edges leaves the byte unchanged until the next edge.
- R7: `data_bus` is driven only while `cs_n` is 0 and `we_n` is 1. In every other case it is high-impedance.
- R8: While `rst_n` is 0, the readout register holds the phantom byte 0x14, whatever the request pins are doing.
- R9: A write cycle (`cs_n` 0, `we_n` 0) changes nothing. The next read returns the byte set by the requests alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the readout register loads on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pin | input | 10 | Request pins, with per-pin polarity as in R2 |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write enable |
| irq_n | output | 1 | Merged active-low interrupt line |
| data_bus | inout | 8 | Tri-state readout byte |

## Verification
Two functions can fall in the same cycle: a request changes while a read of the registered byte is in progress. To provoke this, the bench holds `cs_n` low and changes the request pins a quarter period before a rising edge. The interrupt line must react at once, while the bus must keep the previous byte until that edge and show the new winner only after it. Bus release is judged through a pull-up on the bench wire: a floating bus reads 0xFF, a value the block never drives.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  // Offset byte from an index: index shifted left by one inside a bus word.
  function automatic logic [7:0] index_to_byte(input logic [3:0] idx);
    return {3'b000, idx, 1'b0};
  endfunction
endpackage

// File: rtl/irq_pol_norm.sv
module irq_pol_norm #(
  parameter int unsigned             N_SRC    = 10,
  parameter logic [N_SRC-1:0]        ACT_HIGH = 10'b00_0010_0100
) (
  input  logic [N_SRC-1:0] pin_raw,
  output logic [N_SRC-1:0] req_act
);
  // Each pin is flipped or passed so that 1 always means "requesting".
  for (genvar g = 0; g < N_SRC; g++) begin : g_pin
    if (ACT_HIGH[g]) begin : g_hi
      assign req_act[g] = pin_raw[g];
    end else begin : g_lo
      assign req_act[g] = ~pin_raw[g];
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_SRC = 10,
  localparam int unsigned IDX_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_act,
  output logic [IDX_W-1:0] win_idx,
  output logic             found
);
  localparam logic [IDX_W-1:0] PHANTOM = IDX_W'(N_SRC);

  // Scan from the top down, so the last match left standing is the lowest index.
  always_comb begin
    win_idx = PHANTOM;
    found   = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_act[i]) begin
        win_idx = IDX_W'(i);
        found   = 1'b1;
      end
    end
  end

  // Checker-side mask of all sources below the winner.
  logic [N_SRC-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < N_SRC; i++)
      if (IDX_W'(i) < win_idx) below_mask[i] = 1'b1;
  end

  assert_winner_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req_act[win_idx]);
  assert_none_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((req_act & below_mask) == '0));
  assert_phantom_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_act == '0) |-> (win_idx == PHANTOM));
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned RST_V = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_d,
  output logic [IDX_W-1:0] idx_q
);
  // Reloads every edge, selected or not, so a read sees a settled value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= IDX_W'(RST_V);
    else        idx_q <= idx_d;
  end

  assert_reset_value_R8: assert property (@(posedge clk)
    $rose(rst_n) |-> (idx_q == IDX_W'(RST_V)));
  assert_follows_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(idx_d) |=> (idx_q == $past(idx_d)));
endmodule

// File: rtl/irq_vector_merge.sv
module irq_vector_merge
  import irqv_pkg::*;
#(
  parameter int unsigned      N_SRC    = 10,
  parameter logic [N_SRC-1:0] ACT_HIGH = 10'b00_0010_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_pin,
  input  logic             cs_n,
  input  logic             we_n,
  output logic             irq_n,
  inout  wire  [7:0]       data_bus
);
  localparam int unsigned IDX_W = $clog2(N_SRC + 1);

  logic [N_SRC-1:0] req_act;
  logic [IDX_W-1:0] win_idx, idx_q;
  logic             found;
  logic             rd_en;
  logic [7:0]       vec_byte;

  irq_pol_norm #(.N_SRC(N_SRC), .ACT_HIGH(ACT_HIGH)) u_norm (
    .pin_raw (req_pin),
    .req_act (req_act)
  );

  irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_act (req_act),
    .win_idx (win_idx),
    .found   (found)
  );

  irq_vec_reg #(.IDX_W(IDX_W), .RST_V(N_SRC)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .idx_d (win_idx),
    .idx_q (idx_q)
  );

  // Unclocked merge of all active requests.
  assign irq_n    = ~(|req_act);
  assign rd_en    = ~cs_n & we_n;
  assign vec_byte = index_to_byte(4'(idx_q));
  assign data_bus = rd_en ? vec_byte : 8'bzzzz_zzzz;

  // The merged line and the encoder's own detect must agree.
  always_comb begin
    if (rst_n) assert_line_vs_enc_R1: assert (irq_n == ~found);
  end
  assert_byte_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_byte[0] == 1'b0) && (vec_byte[7:5] == 3'b000));
endmodule

// File: tb/irq_vector_merge_bench.sv
module irq_vector_merge_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] LOW_ACT = 10'b11_1101_1011; // pins that are active-low

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] req_pin = LOW_ACT; // all idle
  logic       cs_n = 1'b0;
  logic       we_n = 1'b1;
  logic       irq_n;
  wire  [7:0] bus_w;
  pullup (bus_w);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  irq_vector_merge u_irq_vector_merge (
    .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .cs_n(cs_n), .we_n(we_n),
    .irq_n(irq_n), .data_bus(bus_w)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_byte(input logic [9:0] act);
    int w = 10;
    for (int i = 9; i >= 0; i--) if (act[i]) w = i;
    return 8'(w * 2);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [9:0] act);
    req_pin = act ^ LOW_ACT;
  endtask

  // Drive a pattern at a falling edge; check the line at once, the byte after an edge.
  task automatic drive_and_read(input string tag, input logic [9:0] act);
    @(negedge clk); apply(act); #1;
    chk({tag, " R1 line"}, {7'd0, irq_n}, {7'd0, ~(|act)});
    @(negedge clk);
    chk({tag, " R5 byte"}, bus_w, exp_byte(act));
  endtask

  task automatic t_reset;
    apply(10'h001);                 // a request during reset must not reach the byte
    #(CLK_PERIOD*3);
    chk("R8 reset byte", bus_w, 8'h14);
    @(negedge clk); apply(10'h000); rst_n = 1'b1;
    @(negedge clk);
    chk("R4 phantom after reset", bus_w, 8'h14);
    chk("R1 idle line", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_single;
    for (int k = 0; k < 10; k++)   // R2 polarity and R5 encoding per pin
      drive_and_read($sformatf("R2 single %0d", k), 10'(1 << k));
  endtask

  task automatic t_multi;         // R3 lowest index wins
    drive_and_read("R3 multi 9+2", 10'h204);
    drive_and_read("R3 multi all", 10'h3FF);
    drive_and_read("R3 multi 5+7+8", 10'h1A0);
    drive_and_read("R3 multi 3+4", 10'h018);
    drive_and_read("R4 phantom", 10'h000);
  endtask

  task automatic t_float;         // R7 bus released unless reading
    drive_and_read("R7 setup", 10'h002);
    @(negedge clk); cs_n = 1'b1; #1;
    chk("R7 deselected float", bus_w, 8'hFF);
    we_n = 1'b0; #1;
    chk("R7 deselect+write float", bus_w, 8'hFF);
    cs_n = 1'b0; #1;
    chk("R7 write float", bus_w, 8'hFF);
    we_n = 1'b1; #1;
    chk("R7 read drives", bus_w, 8'h02);
  endtask

  task automatic t_mid_read;      // R6 byte held across a change between edges
    drive_and_read("R6 setup", 10'h080);
    @(negedge clk); #(CLK_PERIOD/4); apply(10'h004); #1;
    chk("R6 line reacts", {7'd0, irq_n}, 8'd0);
    chk("R6 byte held", bus_w, 8'h0E);
    @(negedge clk);
    chk("R6 byte updated", bus_w, 8'h04);
  endtask

  task automatic t_write;         // R9 write cycle leaves nothing behind
    drive_and_read("R9 setup", 10'h040);
    @(negedge clk); we_n = 1'b0; apply(10'h000);
    @(negedge clk); we_n = 1'b1; #1;
    chk("R9 read after write", bus_w, 8'h14);
  endtask

  initial begin
    t_reset;
    t_single;
    t_multi;
    t_float;
    t_mid_read;
    t_write;
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule